// File: doc/BRIEF.md
# Multi-Decoder Group Allocator

The block sits between the instruction queue and the decoded-µop queue of an out-of-order front end. In every cycle it looks at up to four instruction descriptors at the queue head and decides how many of them are decoded together. The first instruction always takes the complex decoder. Later instructions may take the three simple decoders only if they pass every grouping rule, and allocation stays in program order. The µops the group produces go out as tagged tokens on a lane bus, and the block reports how many descriptors the queue should pop.

An instruction with microcoded µops is decoded on its own. After its decoder part is pushed, the decoders go idle. The block waits an entry stall, streams the remaining µops from a microcode-sequencer phase at a fixed rate, waits an exit stall, and then returns to decoder mode. If the decoded-µop queue reports too little free space for the µops of a cycle, nothing is popped or pushed in that cycle.

Descriptor bit layout (17 bits, LSB first):
- [1:0] simple allowance: the number of simple slots usable after this instruction when it sits in the complex slot.
- [2] fusible.
- [3] complex-only.
- [6:4] decoder µop count, 1 to 4.
- [12:7] microcode µop count.
- [16:13] tag.

Top module: `dec_group_alloc`

## Requirements
- R1: When the block is in decoder mode and queue entry 0 is valid and its µops fit in the free space, entry 0 is popped and its decoder µops fill lanes 0 upward, each carrying its tag.
- R2: A simple slot takes only a valid descriptor with decoder µop count 1, complex-only bit 0 and microcode µop count 0.
- R3: The number of simple slots used in a cycle never exceeds the simple allowance field of the instruction in the complex slot.
- R4: The µops pushed in one cycle never exceed UOP_CAP (default 5). For example, a 3-µop head plus two 1-µop instructions fill one cycle.
- R5: With NO_FUSE_LAST set, an instruction whose fusible bit is 1 is never placed in slot 3. Fusible instructions in slots 1 and 2 are allowed.
- R6: Allocation is in order. The group ends at the first entry that fails a rule or is not valid, even if a later entry would pass.
- R7: If the group's µop total exceeds idq_free_i, the block pops 0 and pushes 0 in that cycle. A total equal to the free space is accepted.
- R8: An instruction with a nonzero microcode µop count is decoded alone. It pops 1 and pushes only its decoder µops.
- R9: The cycle after R8 is an entry stall with no pop and no push. The sequencer then pushes min(MS_RATE, remaining) µops per cycle with the instruction's tag and tok_from_ms_o set. One exit stall follows, and decoding resumes after it. No pop happens during this phase.
- R10: If the sequencer's next chunk is larger than idq_free_i, it pushes nothing in that cycle and keeps its remaining count.
- R11: Token lanes are contiguous from lane 0. The number of valid lanes equals idq_push_cnt_o, and invalid lanes carry tag 0.
- R12: An active-low asynchronous reset returns the block to decoder mode at once, including from the middle of a microcode phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iq_vld_i | input | 4 | Valid bits of queue head entries 0..3 |
| iq_desc_i | input | 68 | Four descriptors, entry 0 in the low 17 bits |
| idq_free_i | input | 7 | Free entries in the decoded-µop queue |
| iq_pop_o | output | 3 | Descriptors consumed this cycle |
| idq_push_cnt_o | output | 3 | µops pushed this cycle |
| tok_vld_o | output | 5 | Token lane valid bits |
| tok_tag_o | output | 20 | Token lane tags, lane 0 in the low 4 bits |
| tok_from_ms_o | output | 1 | Tokens of this cycle come from the sequencer |

## Verification
The hardest case to reach is a sequencer chunk that stalls on a full queue in the middle of the microcode phase. It needs a microcoded instruction to be accepted, the entry stall to pass, and then a drop in idq_free_i timed to land exactly on a sequencer cycle. The bench drives a 10-µop microcode instruction through its phase one cycle at a time. It lowers the free count on the second chunk's successor cycle and checks that the final 2-µop chunk arrives only after space returns. A second directed sequence asserts reset inside the entry stall to confirm that decoding resumes at once.

// File: rtl/dga_pkg.sv
package dga_pkg;
  localparam int SLOTS   = 4;
  localparam int TAG_W   = 4;
  localparam int MS_W    = 6;
  localparam int UOP_W   = 3;
  localparam int ALLOW_W = 2;
  localparam int POP_W   = $clog2(SLOTS + 1);

  typedef struct packed {
    logic [TAG_W-1:0]   tag;
    logic [MS_W-1:0]    ms_uops;
    logic [UOP_W-1:0]   dec_uops;
    logic               cplx_only;
    logic               fusible;
    logic [ALLOW_W-1:0] allow;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  typedef enum logic [1:0] {ST_DEC, ST_ENTER, ST_SEQ, ST_LEAVE} ms_state_e;
endpackage

// File: rtl/dga_group_sel.sv
module dga_group_sel
  import dga_pkg::*;
#(
  parameter int UOP_CAP      = 5,
  parameter bit NO_FUSE_LAST = 1'b1,
  parameter int FREE_W       = 7,
  parameter int CNT_W        = 3
) (
  input  logic [SLOTS-1:0]        vld_i,
  input  logic [SLOTS*DESC_W-1:0] desc_i,
  input  logic [FREE_W-1:0]       free_i,
  output logic [POP_W-1:0]        take_o,
  output logic [CNT_W-1:0]        uops_o,
  output logic                    ms_start_o
);
  desc_t d [SLOTS];
  for (genvar i = 0; i < SLOTS; i++) begin : g_unpack
    assign d[i] = desc_t'(desc_i[i*DESC_W +: DESC_W]);
  end

  always_comb begin
    int   take;
    int   tot;
    logic open;
    take = 0;
    tot  = 0;
    open = 1'b0;
    if (vld_i[0]) begin
      take = 1;
      tot  = int'(d[0].dec_uops);
      open = (d[0].ms_uops == '0);   // microcoded head decodes alone
    end
    for (int k = 1; k < SLOTS; k++) begin
      if (open && vld_i[k] && (k <= int'(d[0].allow)) &&
          (d[k].dec_uops == UOP_W'(1)) && !d[k].cplx_only &&
          (d[k].ms_uops == '0) && (tot + 1 <= UOP_CAP) &&
          !(NO_FUSE_LAST && d[k].fusible && (k == SLOTS-1))) begin
        take = take + 1;
        tot  = tot + 1;
      end else begin
        open = 1'b0;
      end
    end
    if (tot > int'(free_i)) begin
      take = 0;
      tot  = 0;
    end
    take_o     = POP_W'(take);
    uops_o     = CNT_W'(tot);
    ms_start_o = vld_i[0] && (d[0].ms_uops != '0) && (take != 0);
  end
endmodule

// File: rtl/dga_ms_ctrl.sv
module dga_ms_ctrl
  import dga_pkg::*;
#(
  parameter int MS_RATE     = 4,
  parameter int ENTRY_STALL = 1,
  parameter int EXIT_STALL  = 1,
  parameter int FREE_W      = 7,
  parameter int CNT_W       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MS_W-1:0]   ms_uops_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [FREE_W-1:0] free_i,
  output logic              dec_en_o,
  output logic [CNT_W-1:0]  emit_n_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam int STALL_MAX = (ENTRY_STALL > EXIT_STALL) ? ENTRY_STALL : EXIT_STALL;
  localparam int STL_W     = $clog2(STALL_MAX + 1);

  ms_state_e        state_q;
  logic [MS_W-1:0]  rem_q;
  logic [TAG_W-1:0] tag_q;
  logic [STL_W-1:0] cnt_q;
  logic [MS_W-1:0]  chunk;
  logic             fire;

  assign chunk    = (rem_q < MS_W'(MS_RATE)) ? rem_q : MS_W'(MS_RATE);
  assign fire     = (state_q == ST_SEQ) && (int'(chunk) <= int'(free_i));
  assign emit_n_o = fire ? CNT_W'(chunk) : '0;
  assign dec_en_o = (state_q == ST_DEC);
  assign tag_o    = tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DEC;
      rem_q   <= '0;
      tag_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_DEC: if (start_i) begin
          rem_q   <= ms_uops_i;
          tag_q   <= tag_i;
          cnt_q   <= '0;
          state_q <= ST_ENTER;
        end
        ST_ENTER: if (cnt_q == STL_W'(ENTRY_STALL-1)) begin
          cnt_q   <= '0;
          state_q <= ST_SEQ;
        end else cnt_q <= cnt_q + 1'b1;
        ST_SEQ: if (fire) begin
          rem_q <= rem_q - chunk;
          if (rem_q == chunk) begin
            cnt_q   <= '0;
            state_q <= ST_LEAVE;
          end
        end
        ST_LEAVE: if (cnt_q == STL_W'(EXIT_STALL-1)) begin
          cnt_q   <= '0;
          state_q <= ST_DEC;
        end else cnt_q <= cnt_q + 1'b1;
        default: state_q <= ST_DEC;
      endcase
    end
  end

  assert_entry_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_en_o && start_i) |=> (emit_n_o == '0 && !dec_en_o));
  assert_exit_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit_n_o != '0) |=> !dec_en_o);
  assert_ms_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEQ && !fire) |=> $stable(rem_q));
endmodule

// File: rtl/dga_lane_fill.sv
module dga_lane_fill
  import dga_pkg::*;
#(
  parameter int UOP_CAP = 5,
  parameter int CNT_W   = 3
) (
  input  logic                   ms_mode_i,
  input  logic [CNT_W-1:0]       ms_n_i,
  input  logic [TAG_W-1:0]       ms_tag_i,
  input  logic [POP_W-1:0]       take_i,
  input  logic [UOP_W-1:0]       head_uops_i,
  input  logic [SLOTS*TAG_W-1:0] tags_i,
  output logic [UOP_CAP-1:0]     vld_o,
  output logic [UOP_CAP*TAG_W-1:0] tag_o
);
  for (genvar l = 0; l < UOP_CAP; l++) begin : g_lane
    always_comb begin
      vld_o[l] = 1'b0;
      tag_o[l*TAG_W +: TAG_W] = '0;
      if (ms_mode_i) begin
        if (l < int'(ms_n_i)) begin
          vld_o[l] = 1'b1;
          tag_o[l*TAG_W +: TAG_W] = ms_tag_i;
        end
      end else if (take_i != '0) begin
        if (l < int'(head_uops_i)) begin
          vld_o[l] = 1'b1;
          tag_o[l*TAG_W +: TAG_W] = tags_i[TAG_W-1:0];
        end
        for (int k = 1; k < SLOTS; k++) begin
          if ((k < int'(take_i)) && (l == int'(head_uops_i) + k - 1)) begin
            vld_o[l] = 1'b1;
            tag_o[l*TAG_W +: TAG_W] = tags_i[k*TAG_W +: TAG_W];
          end
        end
      end
    end
  end
endmodule

// File: rtl/dec_group_alloc.sv
module dec_group_alloc
  import dga_pkg::*;
#(
  parameter int UOP_CAP      = 5,
  parameter bit NO_FUSE_LAST = 1'b1,
  parameter int MS_RATE      = 4,
  parameter int ENTRY_STALL  = 1,
  parameter int EXIT_STALL   = 1,
  parameter int IDQ_DEPTH    = 64,
  localparam int FREE_W      = $clog2(IDQ_DEPTH + 1),
  localparam int CNT_W       = $clog2(UOP_CAP + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [SLOTS-1:0]         iq_vld_i,
  input  logic [SLOTS*DESC_W-1:0]  iq_desc_i,
  input  logic [FREE_W-1:0]        idq_free_i,
  output logic [POP_W-1:0]         iq_pop_o,
  output logic [CNT_W-1:0]         idq_push_cnt_o,
  output logic [UOP_CAP-1:0]       tok_vld_o,
  output logic [UOP_CAP*TAG_W-1:0] tok_tag_o,
  output logic                     tok_from_ms_o
);
  desc_t                  d [SLOTS];
  logic [SLOTS*TAG_W-1:0] tags;
  logic                   dec_en;
  logic [POP_W-1:0]       take;
  logic [CNT_W-1:0]       grp_uops;
  logic                   ms_start;
  logic [CNT_W-1:0]       ms_n;
  logic [TAG_W-1:0]       ms_tag;

  for (genvar i = 0; i < SLOTS; i++) begin : g_unpack
    assign d[i] = desc_t'(iq_desc_i[i*DESC_W +: DESC_W]);
    assign tags[i*TAG_W +: TAG_W] = d[i].tag;
  end

  dga_group_sel #(
    .UOP_CAP(UOP_CAP), .NO_FUSE_LAST(NO_FUSE_LAST), .FREE_W(FREE_W), .CNT_W(CNT_W)
  ) u_sel (
    .vld_i(iq_vld_i & {SLOTS{dec_en}}), .desc_i(iq_desc_i), .free_i(idq_free_i),
    .take_o(take), .uops_o(grp_uops), .ms_start_o(ms_start)
  );

  dga_ms_ctrl #(
    .MS_RATE(MS_RATE), .ENTRY_STALL(ENTRY_STALL), .EXIT_STALL(EXIT_STALL),
    .FREE_W(FREE_W), .CNT_W(CNT_W)
  ) u_ms (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(ms_start), .ms_uops_i(d[0].ms_uops),
    .tag_i(d[0].tag), .free_i(idq_free_i), .dec_en_o(dec_en), .emit_n_o(ms_n),
    .tag_o(ms_tag)
  );

  assign tok_from_ms_o  = (ms_n != '0);
  assign iq_pop_o       = dec_en ? take : '0;
  assign idq_push_cnt_o = dec_en ? grp_uops : ms_n;

  dga_lane_fill #(.UOP_CAP(UOP_CAP), .CNT_W(CNT_W)) u_fill (
    .ms_mode_i(!dec_en), .ms_n_i(ms_n), .ms_tag_i(ms_tag), .take_i(iq_pop_o),
    .head_uops_i(d[0].dec_uops), .tags_i(tags), .vld_o(tok_vld_o), .tag_o(tok_tag_o)
  );

  assert_simple_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iq_pop_o >= POP_W'(2)) |-> (d[1].dec_uops == UOP_W'(1) && !d[1].cplx_only && d[1].ms_uops == '0));
  assert_allow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iq_pop_o != '0) |-> (int'(iq_pop_o) - 1 <= int'(d[0].allow)));
  assert_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idq_push_cnt_o) <= UOP_CAP);
  assert_fuse_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (NO_FUSE_LAST && iq_pop_o == POP_W'(SLOTS)) |-> !d[SLOTS-1].fusible);
  assert_fits_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idq_push_cnt_o) <= int'(idq_free_i));
  assert_no_pop_ms_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_from_ms_o |-> (iq_pop_o == '0));
  assert_lanes_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((tok_vld_o + 1'b1) & tok_vld_o) == '0) && ($countones(tok_vld_o) == int'(idq_push_cnt_o)));
endmodule

// File: tb/sim_dec_group_alloc.sv
`timescale 1ns/1ps
module sim_dec_group_alloc;
  localparam int NV = 14;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  iq_vld_i = '0;
  logic [67:0] iq_desc_i = '0;
  logic [6:0]  idq_free_i = 7'd64;
  logic [2:0]  iq_pop_o;
  logic [2:0]  idq_push_cnt_o;
  logic [4:0]  tok_vld_o;
  logic [19:0] tok_tag_o;
  logic        tok_from_ms_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  dec_group_alloc u0 (.*);

  function automatic logic [16:0] mkd(input int tag, input int ms, input int du,
                                      input int co, input int fu, input int al);
    return {tag[3:0], ms[5:0], du[2:0], co[0], fu[0], al[1:0]};
  endfunction

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  vld;
    logic [16:0] d3, d2, d1, d0;
    logic [6:0]  free;
    logic [2:0]  pop;
    logic [2:0]  push;
    logic [4:0]  tv;
    logic [19:0] tags;
  } vec_t;

  localparam logic [16:0] H13 = mkd(1,0,1,0,0,3);
  localparam logic [16:0] S2  = mkd(2,0,1,0,0,0);
  localparam logic [16:0] S3  = mkd(3,0,1,0,0,0);
  localparam logic [16:0] S4  = mkd(4,0,1,0,0,0);

  localparam vec_t VECS [NV] = '{
    '{4'd1, 4'hF, S4, S3, S2, H13,              7'd64, 3'd4, 3'd4, 5'h0F, 20'h04321}, // R1
    '{4'd4, 4'hF, S4, S3, S2, mkd(1,0,3,0,0,3), 7'd64, 3'd3, 3'd5, 5'h1F, 20'h32111}, // R4
    '{4'd3, 4'hF, S4, S3, S2, mkd(1,0,1,0,0,1), 7'd64, 3'd2, 3'd2, 5'h03, 20'h00021}, // R3
    '{4'd6, 4'hF, S4, S3, mkd(2,0,2,0,0,0), H13, 7'd64, 3'd1, 3'd1, 5'h01, 20'h00001}, // R6
    '{4'd2, 4'hF, S4, S3, mkd(2,0,1,1,0,0), H13, 7'd64, 3'd1, 3'd1, 5'h01, 20'h00001}, // R2
    '{4'd5, 4'hF, mkd(4,0,1,0,1,0), S3, S2, H13, 7'd64, 3'd3, 3'd3, 5'h07, 20'h00321}, // R5
    '{4'd5, 4'hF, S4, mkd(3,0,1,0,1,0), mkd(2,0,1,0,1,0), mkd(1,0,1,0,1,3),
                                               7'd64, 3'd4, 3'd4, 5'h0F, 20'h04321}, // R5
    '{4'd6, 4'h3, S4, S3, S2, H13,              7'd64, 3'd2, 3'd2, 5'h03, 20'h00021}, // R6
    '{4'd7, 4'hF, S4, S3, S2, H13,              7'd3,  3'd0, 3'd0, 5'h00, 20'h00000}, // R7
    '{4'd7, 4'hF, S4, S3, S2, H13,              7'd4,  3'd4, 3'd4, 5'h0F, 20'h04321}, // R7
    '{4'd1, 4'h0, S4, S3, S2, H13,              7'd64, 3'd0, 3'd0, 5'h00, 20'h00000}, // R1
    '{4'd3, 4'hF, S4, S3, S2, mkd(1,0,1,0,0,0), 7'd64, 3'd1, 3'd1, 5'h01, 20'h00001}, // R3
    '{4'd4, 4'hF, S4, S3, S2, mkd(1,0,4,0,0,3), 7'd64, 3'd2, 3'd5, 5'h1F, 20'h21111}, // R4
    '{4'd2, 4'hF, S4, S3, mkd(2,5,1,0,0,0), H13, 7'd64, 3'd1, 3'd1, 5'h01, 20'h00001}  // R2
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input int pop, input int push,
                            input int tv, input int tags, input bit ms);
    check(iq_pop_o == pop[2:0], req, "pop", iq_pop_o, pop);
    check(idq_push_cnt_o == push[2:0], req, "push", idq_push_cnt_o, push);
    check(tok_vld_o == tv[4:0], req, "lanes", tok_vld_o, tv);
    check(tok_tag_o == tags[19:0], req, "tags", tok_tag_o, tags);
    check(tok_from_ms_o == ms, req, "ms flag", tok_from_ms_o, ms);
  endtask

  task automatic drive(input logic [3:0] v, input logic [16:0] a, input logic [16:0] b,
                       input logic [16:0] c, input logic [16:0] e, input logic [6:0] f);
    @(negedge clk_i);
    iq_vld_i   = v;
    iq_desc_i  = {e, c, b, a};
    idq_free_i = f;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [16:0] mc;
    mc = mkd(7,10,4,0,0,3);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R12: decoder mode after reset
    drive(4'hF, H13, S2, S3, S4, 7'd64);
    expect_out("R12", 4, 4, 'h0F, 'h04321, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].vld, VECS[i].d0, VECS[i].d1, VECS[i].d2, VECS[i].d3, VECS[i].free);
      expect_out($sformatf("R%0d v%0d", VECS[i].req, i), VECS[i].pop, VECS[i].push,
                 VECS[i].tv, VECS[i].tags, 1'b0);
    end

    // R7/R8: microcoded head blocked by space stays in decoder mode
    drive(4'h3, mc, S2, S3, S4, 7'd3);
    expect_out("R7", 0, 0, 0, 0, 1'b0);
    // R8: microcoded head decoded alone
    drive(4'h3, mc, S2, S3, S4, 7'd64);
    expect_out("R8", 1, 4, 'h0F, 'h07777, 1'b0);
    // R9: entry stall
    drive(4'hF, H13, S2, S3, S4, 7'd64);
    expect_out("R9 entry", 0, 0, 0, 0, 1'b0);
    drive(4'hF, H13, S2, S3, S4, 7'd64);
    expect_out("R9 chunk1", 0, 4, 'h0F, 'h07777, 1'b1);
    drive(4'hF, H13, S2, S3, S4, 7'd64);
    expect_out("R9 chunk2", 0, 4, 'h0F, 'h07777, 1'b1);
    // R10: last chunk of 2 waits for space
    drive(4'hF, H13, S2, S3, S4, 7'd1);
    expect_out("R10", 0, 0, 0, 0, 1'b0);
    drive(4'hF, H13, S2, S3, S4, 7'd64);
    expect_out("R9 chunk3", 0, 2, 'h03, 'h00077, 1'b1);
    drive(4'hF, H13, S2, S3, S4, 7'd64);
    expect_out("R9 exit", 0, 0, 0, 0, 1'b0);
    drive(4'hF, H13, S2, S3, S4, 7'd64);
    expect_out("R9 resume", 4, 4, 'h0F, 'h04321, 1'b0);

    // R12: reset inside the entry stall
    drive(4'h1, mc, S2, S3, S4, 7'd64);
    expect_out("R12 start", 1, 4, 'h0F, 'h07777, 1'b0);
    drive(4'hF, H13, S2, S3, S4, 7'd64);
    expect_out("R12 stalled", 0, 0, 0, 0, 1'b0);
    rst_ni = 1'b0;
    #1;
    expect_out("R12 async", 4, 4, 'h0F, 'h04321, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(4'hF, H13, S2, S3, S4, 7'd64);
    expect_out("R12 after", 4, 4, 'h0F, 'h04321, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule